// File: doc/BRIEF.md
# Queue Interrupt Aggregator

This block turns the status of 64 hardware queues into two interrupt lines, one for queues 0 to 31 (the lower half) and one for queues 32 to 63 (the upper half). Every lower-half queue reports four status flags and carries a small per-queue selector. The selector chooses which flag drives that queue's interrupt condition and can optionally invert it. Upper-half queues have no selector. Their condition is always the not-nearly-empty bit, held in a dedicated 32-bit status word.

A status producer and the interrupt software share one plain register port: a synchronous write and a combinational read. Through this port they update the status words, program the selectors, and set per-queue enable bits. They also read and clear per-queue pending bits by writing ones. A pending bit latches when its queue's selected condition rises while the queue is enabled. Each half's interrupt output is asserted whenever any enabled queue of that half has a pending bit.

Top module: `qirq_aggregator`

## Requirements
- R1: After reset, the four lower status words read 0x33333333, the source selectors read 0, the upper not-nearly-empty word reads 0xFFFFFFFF, the upper full word reads 0, and both enable words and both pending words read 0. Both interrupt outputs are low.
- R2: Lower queue q uses the 4-bit nibble at bits 4*(q mod 8)+3 : 4*(q mod 8) of status word q/8, where flag i is nibble bit i. It also uses the nibble at the same position of selector word q/8. The selector's bits 1:0 pick the flag index, and its bit 2 inverts the picked flag, giving the queue's condition.
- R3: The condition of upper queue 32+k is bit k of the not-nearly-empty word. Writes to the upper full word are stored and read back, but they change no pending bit and no interrupt.
- R4: A pending bit sets on the clock edge that follows a cycle in which its queue's condition is 1 and was 0 in the cycle before, provided the queue is enabled after that edge. It is visible one edge after the status or selector write that caused the rise.
- R5: Writing a word to a pending register clears every pending bit whose written bit is 1. Bits written as 0 are unaffected.
- R6: Writing an enable word that turns an enable bit from 1 to 0 clears that queue's pending bit on the same edge. A queue whose enable is 0 never gets a pending bit.
- R7: When a pending set and a write-one-to-clear of the same bit land on the same edge, the bit ends set.
- R8: irq_lo is high exactly when some bit is 1 in both the lower pending word and the lower enable word. irq_hi follows the same rule for the upper words. Both follow the registers with no extra delay.
- R9: In each selector nibble bit 3 is reserved: it is dropped on write and always reads 0.
- R10: Word addresses are: 0 to 3 lower status words, 4 to 7 selector words, 8 upper not-nearly-empty, 9 upper full, 10 lower enable, 11 upper enable, 12 lower pending, 13 upper pending. Reads of 14 and 15 return 0, writes to them have no effect, and rd_data reflects rd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe for the current cycle |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_lo | output | 1 | Interrupt for queues 0 to 31 |
| irq_hi | output | 1 | Interrupt for queues 32 to 63 |

## Verification
The assertions assume the register port sees at most one write per cycle. They also assume that status words change only through that port, so that a condition can rise only in the cycle after a status or selector write. The bench drives writes from a single sequence at the falling edge and never overlaps two writes. Its random mix covers all fourteen addresses with full 32-bit data. This deliberately produces back-to-back status writes, enable writes and clears, which brings rise, disable and clear onto the same edges.

// File: rtl/qirq_pkg.sv
`timescale 1ns/1ps
package qirq_pkg;
  localparam int HALF_Q         = 32;
  localparam int REG_W          = 32;
  localparam int NIB_W          = 4;
  localparam int FLAG_N         = 4;
  localparam int ADDR_W         = 4;
  localparam int LANES_PER_WORD = REG_W / NIB_W;
  localparam int WORDS          = HALF_Q / LANES_PER_WORD;

  localparam logic [ADDR_W-1:0] A_STAT0   = '0;
  localparam logic [ADDR_W-1:0] A_SEL0    = ADDR_W'(WORDS);
  localparam logic [ADDR_W-1:0] A_NE_HI   = ADDR_W'(2 * WORDS);
  localparam logic [ADDR_W-1:0] A_FULL_HI = ADDR_W'(2 * WORDS + 1);
  localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(2 * WORDS + 2);
  localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(2 * WORDS + 3);
  localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(2 * WORDS + 4);
  localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(2 * WORDS + 5);

  localparam logic [REG_W-1:0] STAT_RST = {LANES_PER_WORD{4'h3}};
  localparam logic [REG_W-1:0] SEL_MASK = {LANES_PER_WORD{4'h7}};

  // Selected flag of one queue: low two selector bits index, bit 2 inverts.
  function automatic logic pick_flag(input logic [FLAG_N-1:0] flags,
                                     input logic [2:0] sel);
    return flags[sel[1:0]] ^ sel[2];
  endfunction

  // Rising condition: high now, low in the previous cycle.
  function automatic logic [REG_W-1:0] rise_of(input logic [REG_W-1:0] now_v,
                                               input logic [REG_W-1:0] old_v);
    return now_v & ~old_v;
  endfunction

  // Pending update: clears first, sets override clears.
  function automatic logic [REG_W-1:0] pend_update(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] clr,
                                                   input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Bits that an enable write turns off.
  function automatic logic [REG_W-1:0] falling_en(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] nxt);
    return cur & ~nxt;
  endfunction
endpackage

// File: rtl/qirq_regs.sv
`timescale 1ns/1ps
module qirq_regs
  import qirq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [REG_W-1:0]           wr_data,
  output logic [HALF_Q*FLAG_N-1:0]   stat_lo,
  output logic [HALF_Q*NIB_W-1:0]    src_lo,
  output logic [REG_W-1:0]           ne_hi,
  output logic [REG_W-1:0]           full_hi,
  output logic [REG_W-1:0]           en_lo,
  output logic [REG_W-1:0]           en_hi,
  output logic [REG_W-1:0]           en_lo_nxt,
  output logic [REG_W-1:0]           en_hi_nxt,
  output logic [REG_W-1:0]           w1c_lo,
  output logic [REG_W-1:0]           w1c_hi
);
  logic hit_ne, hit_full, hit_en_lo, hit_en_hi, hit_pd_lo, hit_pd_hi;

  assign hit_ne    = wr_en && (wr_addr == A_NE_HI);
  assign hit_full  = wr_en && (wr_addr == A_FULL_HI);
  assign hit_en_lo = wr_en && (wr_addr == A_EN_LO);
  assign hit_en_hi = wr_en && (wr_addr == A_EN_HI);
  assign hit_pd_lo = wr_en && (wr_addr == A_PEND_LO);
  assign hit_pd_hi = wr_en && (wr_addr == A_PEND_HI);

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic             hit_stat, hit_src;
      logic [REG_W-1:0] stat_q, src_q;
      assign hit_stat = wr_en && (wr_addr == A_STAT0 + ADDR_W'(w));
      assign hit_src  = wr_en && (wr_addr == A_SEL0 + ADDR_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q <= STAT_RST;
          src_q  <= '0;
        end else begin
          if (hit_stat) stat_q <= wr_data;
          if (hit_src)  src_q  <= wr_data & SEL_MASK;
        end
      end

      assign stat_lo[w*REG_W +: REG_W] = stat_q;
      assign src_lo[w*REG_W +: REG_W]  = src_q;
    end
  endgenerate

  assign en_lo_nxt = hit_en_lo ? wr_data : en_lo;
  assign en_hi_nxt = hit_en_hi ? wr_data : en_hi;
  assign w1c_lo    = hit_pd_lo ? wr_data : '0;
  assign w1c_hi    = hit_pd_hi ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_hi   <= '1;
      full_hi <= '0;
      en_lo   <= '0;
      en_hi   <= '0;
    end else begin
      if (hit_ne)   ne_hi   <= wr_data;
      if (hit_full) full_hi <= wr_data;
      en_lo <= en_lo_nxt;
      en_hi <= en_hi_nxt;
    end
  end
endmodule

// File: rtl/qirq_lo_cond.sv
`timescale 1ns/1ps
module qirq_lo_cond
  import qirq_pkg::*;
(
  input  logic [HALF_Q*FLAG_N-1:0] stat_lo,
  input  logic [HALF_Q*NIB_W-1:0]  src_lo,
  output logic [HALF_Q-1:0]        cond_lo
);
  generate
    for (genvar q = 0; q < HALF_Q; q++) begin : g_lane
      logic unused_rsvd;
      assign unused_rsvd = src_lo[q*NIB_W + 3];
      assign cond_lo[q]  = pick_flag(stat_lo[q*FLAG_N +: FLAG_N],
                                     src_lo[q*NIB_W +: 3]);
    end
  endgenerate
endmodule

// File: rtl/qirq_pend.sv
`timescale 1ns/1ps
module qirq_pend
  import qirq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic [W-1:0] en_cur,
  input  logic [W-1:0] en_nxt,
  input  logic [W-1:0] w1c,
  output logic [W-1:0] rise,
  output logic [W-1:0] pend
);
  logic [W-1:0] cond_prev;
  logic [W-1:0] set_evt;
  logic [W-1:0] clr_evt;

  assign rise    = rise_of(cond, cond_prev);
  assign set_evt = rise & en_nxt;
  assign clr_evt = w1c | falling_en(en_cur, en_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_prev <= '1;
      pend      <= '0;
    end else begin
      cond_prev <= cond;
      pend      <= pend_update(pend, clr_evt, set_evt);
    end
  end
endmodule

// File: rtl/qirq_aggregator.sv
`timescale 1ns/1ps
module qirq_aggregator
  import qirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_lo,
  output logic              irq_hi
);
  logic [HALF_Q*FLAG_N-1:0] stat_lo;
  logic [HALF_Q*NIB_W-1:0]  src_lo;
  logic [REG_W-1:0] ne_hi, full_hi;
  logic [REG_W-1:0] en_lo, en_hi, en_lo_nxt, en_hi_nxt;
  logic [REG_W-1:0] w1c_lo, w1c_hi;
  logic [REG_W-1:0] cond_lo;
  logic [REG_W-1:0] rise_lo, rise_hi;
  logic [REG_W-1:0] pend_lo, pend_hi;

  qirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat_lo(stat_lo), .src_lo(src_lo),
    .ne_hi(ne_hi), .full_hi(full_hi), .en_lo(en_lo), .en_hi(en_hi),
    .en_lo_nxt(en_lo_nxt), .en_hi_nxt(en_hi_nxt),
    .w1c_lo(w1c_lo), .w1c_hi(w1c_hi)
  );

  qirq_lo_cond u_cond (
    .stat_lo(stat_lo), .src_lo(src_lo), .cond_lo(cond_lo)
  );

  qirq_pend #(.W(REG_W)) u_pend_lo (
    .clk(clk), .rst_n(rst_n), .cond(cond_lo), .en_cur(en_lo),
    .en_nxt(en_lo_nxt), .w1c(w1c_lo), .rise(rise_lo), .pend(pend_lo)
  );

  qirq_pend #(.W(REG_W)) u_pend_hi (
    .clk(clk), .rst_n(rst_n), .cond(ne_hi), .en_cur(en_hi),
    .en_nxt(en_hi_nxt), .w1c(w1c_hi), .rise(rise_hi), .pend(pend_hi)
  );

  assign irq_lo = |(pend_lo & en_lo);
  assign irq_hi = |(pend_hi & en_hi);

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_addr == A_STAT0 + ADDR_W'(w)) rd_data = stat_lo[w*REG_W +: REG_W];
      if (rd_addr == A_SEL0 + ADDR_W'(w))  rd_data = src_lo[w*REG_W +: REG_W];
    end
    case (rd_addr)
      A_NE_HI:   rd_data = ne_hi;
      A_FULL_HI: rd_data = full_hi;
      A_EN_LO:   rd_data = en_lo;
      A_EN_HI:   rd_data = en_hi;
      A_PEND_LO: rd_data = pend_lo;
      A_PEND_HI: rd_data = pend_hi;
      default:   ;
    endcase
  end
endmodule

// File: rtl/qirq_chk.sv
`timescale 1ns/1ps
module qirq_chk
  import qirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  en_lo,
  input logic [REG_W-1:0]  en_hi,
  input logic [REG_W-1:0]  rise_lo,
  input logic [REG_W-1:0]  rise_hi,
  input logic [REG_W-1:0]  pend_lo,
  input logic [REG_W-1:0]  pend_hi,
  input logic              irq_lo,
  input logic              irq_hi
);
  AST_PEND_IN_EN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_lo & ~en_lo) == '0); // R6
  AST_PEND_IN_EN_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hi & ~en_hi) == '0); // R6
  AST_SET_NEEDS_RISE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_lo & ~$past(pend_lo) & ~$past(rise_lo)) == '0)); // R4
  AST_SET_NEEDS_RISE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_hi & ~$past(pend_hi) & ~$past(rise_hi)) == '0)); // R4
  AST_SET_WINS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_EN_LO) |=>
      ((pend_lo & $past(rise_lo & en_lo)) == $past(rise_lo & en_lo))); // R7
  AST_SET_WINS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_EN_HI) |=>
      ((pend_hi & $past(rise_hi & en_hi)) == $past(rise_hi & en_hi))); // R7
  AST_W1C_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PEND_LO) |=>
      ((pend_lo & $past(wr_data & ~rise_lo)) == '0)); // R5
  AST_W1C_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PEND_HI) |=>
      ((pend_hi & $past(wr_data & ~rise_hi)) == '0)); // R5
  AST_DISABLE_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EN_HI) |=> ((pend_hi & ~$past(wr_data)) == '0)); // R6
  AST_IRQ_QUIET_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_lo == '0) |-> !irq_lo); // R8
  AST_IRQ_QUIET_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hi == '0) |-> !irq_hi); // R8
endmodule

bind qirq_aggregator qirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .en_lo(en_lo), .en_hi(en_hi),
  .rise_lo(rise_lo), .rise_hi(rise_hi), .pend_lo(pend_lo),
  .pend_hi(pend_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_qirq_aggregator.sv
`timescale 1ns/1ps
module tb_qirq_aggregator;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [3:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        irq_lo, irq_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  qirq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  logic [31:0] m_stat [4];
  logic [31:0] m_sel  [4];
  logic [31:0] m_ne, m_full, m_en_lo, m_en_hi, m_pend_lo, m_pend_hi;
  logic [31:0] m_prev_lo, m_prev_hi;

  function automatic logic [31:0] model_cond_lo();
    logic [31:0] c;
    for (int q = 0; q < 32; q++) begin
      logic [3:0] f, s;
      logic b;
      f = 4'((m_stat[q/8] >> (4*(q%8))) & 32'hF);
      s = 4'((m_sel[q/8]  >> (4*(q%8))) & 32'hF);
      b = f[s[1:0]];
      if (s[2]) b = !b;
      c[q] = b;
    end
    return c;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a < 4)        return m_stat[a];
    else if (a < 8)   return m_sel[a-4];
    case (a)
      4'd8:  return m_ne;
      4'd9:  return m_full;
      4'd10: return m_en_lo;
      4'd11: return m_en_hi;
      4'd12: return m_pend_lo;
      4'd13: return m_pend_hi;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a < 4) return "R2 status";
    if (a < 8) return "R9 selector";
    if (a < 10) return "R3 upper";
    if (a < 12) return "R6 enable";
    if (a < 14) return "R5 pending";
    return "R10 unmapped";
  endfunction

  function automatic logic [31:0] reset_val(input logic [3:0] a);
    if (a < 4) return 32'h3333_3333;
    if (a == 8) return 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] c_lo, r_lo, r_hi, en_lo_n, en_hi_n, clr_lo, clr_hi;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_stat[i] = 32'h3333_3333;
        m_sel[i]  = 32'h0;
      end
      m_ne = '1; m_full = '0; m_en_lo = '0; m_en_hi = '0;
      m_pend_lo = '0; m_pend_hi = '0; m_prev_lo = '1; m_prev_hi = '1;
    end else begin
      c_lo = model_cond_lo();
      r_lo = c_lo & ~m_prev_lo;
      r_hi = m_ne & ~m_prev_hi;
      m_prev_lo = c_lo;
      m_prev_hi = m_ne;
      en_lo_n = m_en_lo; en_hi_n = m_en_hi; clr_lo = '0; clr_hi = '0;
      if (wr_en) begin
        if (wr_addr == 4'd10) en_lo_n = wr_data;
        if (wr_addr == 4'd11) en_hi_n = wr_data;
        if (wr_addr == 4'd12) clr_lo = wr_data;
        if (wr_addr == 4'd13) clr_hi = wr_data;
      end
      clr_lo = clr_lo | (m_en_lo & ~en_lo_n);
      clr_hi = clr_hi | (m_en_hi & ~en_hi_n);
      m_pend_lo = (m_pend_lo & ~clr_lo) | (r_lo & en_lo_n);
      m_pend_hi = (m_pend_hi & ~clr_hi) | (r_hi & en_hi_n);
      m_en_lo = en_lo_n;
      m_en_hi = en_hi_n;
      if (wr_en) begin
        if (wr_addr < 4)       m_stat[wr_addr] = wr_data;
        else if (wr_addr < 8)  m_sel[wr_addr-4] = wr_data & 32'h7777_7777;
        else if (wr_addr == 8) m_ne = wr_data;
        else if (wr_addr == 9) m_full = wr_data;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R8 irq_lo", {31'b0, irq_lo}, {31'b0, |(m_pend_lo & m_en_lo)});
      chk("R8 irq_hi", {31'b0, irq_hi}, {31'b0, |(m_pend_hi & m_en_hi)});
      chk(tag_of(rd_addr), rd_data, m_read(rd_addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    rd_addr = a;
    #2;
    chk(tag, rd_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R1 / R10: reset values over the whole map
    for (int a = 0; a < 16; a++) expect_reg(4'(a), reset_val(4'(a)), "R1 reset value");
    chk("R1 irq_lo reset", {31'b0, irq_lo}, 32'h0);
    chk("R1 irq_hi reset", {31'b0, irq_hi}, 32'h0);
    idle();

    // R2: queue 5 selects flag 2 inverted
    wr(4'd4, 32'h0060_0000);
    wr(4'd10, 32'h0000_0020);
    wr(4'd0, 32'h3343_3333);   // flag2=1 -> condition 0
    wr(4'd0, 32'h3303_3333);   // flag2=0 -> condition 1 (rise)
    idle();
    expect_reg(4'd12, 32'h0000_0020, "R4 pending after rise");
    chk("R2 irq_lo on inverted flag", {31'b0, irq_lo}, 32'h1);

    // R5: clear by writing one
    wr(4'd12, 32'h0000_0020);
    expect_reg(4'd12, 32'h0, "R5 w1c clears");
    chk("R5 irq_lo after clear", {31'b0, irq_lo}, 32'h0);

    // R7: set and clear on the same edge
    wr(4'd0, 32'h3343_3333);
    wr(4'd0, 32'h3303_3333);
    wr(4'd12, 32'h0000_0020);
    expect_reg(4'd12, 32'h0000_0020, "R7 set beats clear");

    // R6: disabling clears, rise while disabled is ignored
    wr(4'd10, 32'h0);
    expect_reg(4'd12, 32'h0, "R6 disable clears pending");
    wr(4'd0, 32'h3343_3333);
    wr(4'd0, 32'h3303_3333);
    idle();
    expect_reg(4'd12, 32'h0, "R6 no set while disabled");
    chk("R6 irq_lo stays low", {31'b0, irq_lo}, 32'h0);

    // R3: upper queue 40 uses not-nearly-empty bit 8, full word ignored
    wr(4'd11, 32'h0000_0100);
    wr(4'd8, ~32'h0000_0100);
    wr(4'd8, 32'hFFFF_FFFF);
    idle();
    expect_reg(4'd13, 32'h0000_0100, "R3 upper pending");
    chk("R8 irq_hi raised", {31'b0, irq_hi}, 32'h1);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd9, 32'h0);
    idle();
    expect_reg(4'd13, 32'h0000_0100, "R3 full word no effect");
    wr(4'd13, 32'hFFFF_FFFF);
    expect_reg(4'd13, 32'h0, "R5 upper w1c");

    // R9: reserved selector bits
    wr(4'd5, 32'hFFFF_FFFF);
    expect_reg(4'd5, 32'h7777_7777, "R9 reserved bits read zero");
    // R10: unmapped write has no effect
    wr(4'd14, 32'hFFFF_FFFF);
    expect_reg(4'd14, 32'h0, "R10 unmapped reads zero");

    // random phase, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      rd_addr = 4'($urandom_range(0, 13));
      if ($urandom_range(0, 1) == 1)
        wr(4'($urandom_range(0, 13)), $urandom());
      else
        idle();
    end
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule